// File: doc/BRIEF.md
# Memory access watchpoint unit

This block sits beside a memory arbiter and observes the transaction that the arbiter grants in each cycle. It holds a set of independent watchpoints, four by default. Each watchpoint is given an inclusive address window, a choice of which access directions it reacts to, and a set of requesting clients. A granted transaction that satisfies all three conditions of a watchpoint is a hit. A hit latches a pending status bit for that watchpoint. It also records the details of the access in capture registers that software can read.

Software programs the watchpoints through a simple word-addressed register port. Writes are synchronous and reads are combinational. An interrupt mask selects which pending bits drive the single interrupt output. Pending bits are cleared by a write-one-to-clear acknowledge register. Each watchpoint also has its own capture acknowledge, which releases its frozen capture so that a later hit can load it again. The unit only observes. It never stalls, blocks or alters the transactions it watches.

Top module: `mem_watch_unit`

## Requirements
- R1: After reset every configuration register, capture register, the interrupt mask and the pending status read as zero, and `irq` is low.
- R2: Watchpoint i hits in a cycle exactly when `txn_valid` is high, first address <= `txn_addr` <= last address (both ends inclusive), the direction is enabled in its direction mask (bit 0 enables reads, bit 1 enables writes, and `txn_write`=1 means write), and bit `txn_client` of its client mask is set.
- R3: A hit sets pending bit i in the raw status register on the next clock edge, whether or not the watchpoint is masked. The bit then stays set until it is acknowledged.
- R4: In the interrupt mask, bit i (value 1, 2, 4, 8) enables watchpoint i. The masked status is raw status AND mask, and `irq` is high exactly when some masked status bit is set.
- R5: Writing the acknowledge register clears each raw status bit whose written bit is 1. A hit on the same watchpoint in the same cycle wins, and the bit stays set.
- R6: The first hit after reset or after a capture acknowledge loads the capture with the address, the direction (info bits [5:4]: 01 read, 10 write), the client index (info bits [3:0]) and `txn_size` (info bits [11:8]), and sets the valid flag (info bit 15). Later hits leave these fields unchanged.
- R7: The captured client set (offset 4) is the OR of the one-hot client bits of every hit since the capture was loaded.
- R8: Any write to a watchpoint's capture-acknowledge offset clears its capture, so that all capture registers read zero, unless a hit in that cycle reloads it. This write does not change the raw status.
- R9: Watchpoints are independent. A single transaction may hit several of them, and it sets each of their pending bits.
- R10: Register map (word addresses): watchpoint i occupies 8*i+0 first address, +1 last address, +2 direction mask [1:0], +3 client mask [15:0], +4 captured client set (read only), +5 captured address (read only), +6 capture info (read only), +7 capture acknowledge (write only). The global registers are at 32 interrupt mask, 33 raw status, 34 masked status and 35 acknowledge. The configuration registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| txn_valid | input | 1 | A granted transaction is present this cycle |
| txn_addr | input | 32 | Transaction byte address |
| txn_write | input | 1 | 1 for write, 0 for read |
| txn_client | input | 4 | Index of the requesting client |
| txn_size | input | 4 | Transfer size code of the transaction |
| irq | output | 1 | Interrupt, OR of masked status |

## Verification
A wrong window comparison or a wrong mask decode shows up in the raw status register one edge after the offending transaction. For this reason the vector table reads raw status after every single transaction, at window edges just inside and just outside. A capture that fails to freeze, or that loses accumulated clients, is visible as soon as the second hit has been clocked in: the info word changes or the client set lacks a bit. A status bit that leaks between the acknowledge paths shows up when the other register is read straight after a capture acknowledge or an interrupt acknowledge.

// File: rtl/mwu_pkg.sv
package mwu_pkg;

   // Word offsets inside one watchpoint's register block
   typedef enum logic [2:0] {
      OFF_FIRST    = 3'd0,
      OFF_LAST     = 3'd1,
      OFF_DIRS     = 3'd2,
      OFF_CLIENTS  = 3'd3,
      OFF_CAP_CLI  = 3'd4,
      OFF_CAP_ADDR = 3'd5,
      OFF_CAP_INFO = 3'd6,
      OFF_CAP_ACK  = 3'd7
   } wp_off_e;

   // Word offsets inside the global register block
   localparam logic [1:0] GLB_MASK   = 2'd0;
   localparam logic [1:0] GLB_RAW    = 2'd1;
   localparam logic [1:0] GLB_MASKED = 2'd2;
   localparam logic [1:0] GLB_ACK    = 2'd3;

   // Direction encoding shared by the mask and the capture
   localparam logic [1:0] DIR_RD = 2'b01;
   localparam logic [1:0] DIR_WR = 2'b10;

   localparam int WP_WORDS = 8;

endpackage

// File: rtl/mwu_watchpoint.sv
module mwu_watchpoint
   import mwu_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int NCLI   = 16,
   parameter int SIZE_W = 4,
   parameter int DATA_W = 32,
   localparam int CLI_W = $clog2(NCLI)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  wp_off_e           cfg_off,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              txn_valid,
   input  logic [ADDR_W-1:0] txn_addr,
   input  logic              txn_write,
   input  logic [CLI_W-1:0]  txn_client,
   input  logic [SIZE_W-1:0] txn_size,
   output logic              hit,
   output logic [DATA_W-1:0] rdata
);

   generate
      if (SIZE_W > 4 || NCLI > 16 || NCLI < 2 || (1 << CLI_W) != NCLI ||
          ADDR_W > DATA_W || DATA_W < 16) begin : g_bad_cfg
         $error("mwu_watchpoint: unsupported parameter combination");
      end
   endgenerate

   logic [ADDR_W-1:0] first_q, last_q, cap_addr_q;
   logic [1:0]        dirs_q, cap_dir_q;
   logic [NCLI-1:0]   cmask_q, cap_set_q;
   logic [CLI_W-1:0]  cap_first_q;
   logic [SIZE_W-1:0] cap_size_q;
   logic              cap_valid_q;

   logic [1:0]        txn_dir;
   logic [NCLI-1:0]   txn_onehot;
   logic              in_window, dir_ok, cli_ok, cap_ack;

   assign txn_dir    = txn_write ? DIR_WR : DIR_RD;
   assign txn_onehot = NCLI'(1) << txn_client;
   assign in_window  = (txn_addr >= first_q) && (txn_addr <= last_q);
   assign dir_ok     = |(dirs_q & txn_dir);
   assign cli_ok     = cmask_q[txn_client];
   assign hit        = txn_valid && in_window && dir_ok && cli_ok;
   assign cap_ack    = cfg_we && (cfg_off == OFF_CAP_ACK);

   // Configuration registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_q <= '0;
         last_q  <= '0;
         dirs_q  <= '0;
         cmask_q <= '0;
      end else if (cfg_we) begin
         case (cfg_off)
            OFF_FIRST:   first_q <= cfg_wdata[ADDR_W-1:0];
            OFF_LAST:    last_q  <= cfg_wdata[ADDR_W-1:0];
            OFF_DIRS:    dirs_q  <= cfg_wdata[1:0];
            OFF_CLIENTS: cmask_q <= cfg_wdata[NCLI-1:0];
            default: ;
         endcase
      end
   end

   // Capture: fields freeze on first hit, client set accumulates
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_valid_q <= 1'b0;
         cap_addr_q  <= '0;
         cap_dir_q   <= '0;
         cap_first_q <= '0;
         cap_size_q  <= '0;
         cap_set_q   <= '0;
      end else if (cap_ack || (hit && !cap_valid_q)) begin
         cap_valid_q <= hit;
         cap_addr_q  <= hit ? txn_addr   : '0;
         cap_dir_q   <= hit ? txn_dir    : '0;
         cap_first_q <= hit ? txn_client : '0;
         cap_size_q  <= hit ? txn_size   : '0;
         cap_set_q   <= hit ? txn_onehot : '0;
      end else if (hit) begin
         cap_set_q   <= cap_set_q | txn_onehot;
      end
   end

   logic [15:0] info;
   always_comb begin
      info                 = '0;
      info[15]             = cap_valid_q;
      info[8 +: SIZE_W]    = cap_size_q;
      info[5:4]            = cap_dir_q;
      info[0 +: CLI_W]     = cap_first_q;
   end

   always_comb begin
      case (cfg_off)
         OFF_FIRST:    rdata = DATA_W'(first_q);
         OFF_LAST:     rdata = DATA_W'(last_q);
         OFF_DIRS:     rdata = DATA_W'(dirs_q);
         OFF_CLIENTS:  rdata = DATA_W'(cmask_q);
         OFF_CAP_CLI:  rdata = DATA_W'(cap_set_q);
         OFF_CAP_ADDR: rdata = DATA_W'(cap_addr_q);
         OFF_CAP_INFO: rdata = DATA_W'(info);
         default:      rdata = '0;
      endcase
   end

   // Capture behaviour checks
   assert_capture_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> cap_valid_q);
   assert_capture_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_valid_q && !cap_ack) |=> ($stable(cap_addr_q) && $stable(cap_first_q)
                                     && $stable(cap_dir_q) && $stable(cap_size_q)));
   assert_client_accum_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !cap_ack) |=> cap_set_q[$past(txn_client)]);
   assert_capture_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_ack && !hit) |=> (!cap_valid_q && cap_set_q == '0));

endmodule

// File: rtl/mwu_irq_ctrl.sv
module mwu_irq_ctrl #(
   parameter int NUM_WP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_WP-1:0] hit,
   input  logic              mask_we,
   input  logic              ack_we,
   input  logic [NUM_WP-1:0] wbits,
   output logic [NUM_WP-1:0] mask_q,
   output logic [NUM_WP-1:0] raw_q,
   output logic [NUM_WP-1:0] masked,
   output logic              irq
);

   logic [NUM_WP-1:0] clr;
   assign clr = ack_we ? wbits : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw_q  <= '0;
         mask_q <= '0;
      end else begin
         raw_q <= (raw_q & ~clr) | hit;
         if (mask_we) mask_q <= wbits;
      end
   end

   assign masked = raw_q & mask_q;
   assign irq    = |masked;

   generate
      for (genvar i = 0; i < NUM_WP; i++) begin : g_chk
         assert_raw_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> raw_q[i]);
         assert_raw_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (raw_q[i] && !(ack_we && wbits[i])) |=> raw_q[i]);
         assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_we && wbits[i] && !hit[i]) |=> !raw_q[i]);
      end
   endgenerate

endmodule

// File: rtl/mem_watch_unit.sv
module mem_watch_unit
   import mwu_pkg::*;
#(
   parameter int NUM_WP = 4,
   parameter int ADDR_W = 32,
   parameter int NCLI   = 16,
   parameter int SIZE_W = 4,
   parameter int DATA_W = 32,
   localparam int CLI_W    = $clog2(NCLI),
   localparam int GLB_BASE = NUM_WP * WP_WORDS,
   localparam int REG_AW   = $clog2(GLB_BASE + 4)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              txn_valid,
   input  logic [ADDR_W-1:0] txn_addr,
   input  logic              txn_write,
   input  logic [CLI_W-1:0]  txn_client,
   input  logic [SIZE_W-1:0] txn_size,
   output logic              irq
);

   generate
      if (NUM_WP < 1 || NUM_WP > DATA_W) begin : g_bad_cfg
         $error("mem_watch_unit: NUM_WP out of range");
      end
   endgenerate

   localparam int IDX_W = REG_AW - 3;

   logic              glb_sel;
   logic [1:0]        glb_off;
   logic [IDX_W-1:0]  wp_idx;
   logic [NUM_WP-1:0] hits, mask_q, raw_q, masked;
   logic [DATA_W-1:0] wp_rdata [NUM_WP];

   assign glb_sel = reg_addr >= REG_AW'(GLB_BASE);
   assign glb_off = reg_addr[1:0];
   assign wp_idx  = reg_addr[REG_AW-1:3];

   generate
      for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
         logic sel;
         assign sel = reg_we && !glb_sel && (wp_idx == IDX_W'(i));
         mwu_watchpoint #(
            .ADDR_W(ADDR_W), .NCLI(NCLI), .SIZE_W(SIZE_W), .DATA_W(DATA_W)
         ) i_wp (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (sel),
            .cfg_off   (wp_off_e'(reg_addr[2:0])),
            .cfg_wdata (reg_wdata),
            .txn_valid (txn_valid),
            .txn_addr  (txn_addr),
            .txn_write (txn_write),
            .txn_client(txn_client),
            .txn_size  (txn_size),
            .hit       (hits[i]),
            .rdata     (wp_rdata[i])
         );
      end
   endgenerate

   mwu_irq_ctrl #(.NUM_WP(NUM_WP)) i_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (hits),
      .mask_we(reg_we && glb_sel && glb_off == GLB_MASK),
      .ack_we (reg_we && glb_sel && glb_off == GLB_ACK),
      .wbits  (reg_wdata[NUM_WP-1:0]),
      .mask_q (mask_q),
      .raw_q  (raw_q),
      .masked (masked),
      .irq    (irq)
   );

   always_comb begin
      reg_rdata = '0;
      if (glb_sel) begin
         case (glb_off)
            GLB_MASK:   reg_rdata = DATA_W'(mask_q);
            GLB_RAW:    reg_rdata = DATA_W'(raw_q);
            GLB_MASKED: reg_rdata = DATA_W'(masked);
            default:    reg_rdata = '0;
         endcase
      end else begin
         for (int i = 0; i < NUM_WP; i++)
            if (wp_idx == IDX_W'(i)) reg_rdata = wp_rdata[i];
      end
   end

   // Interrupt only with an enabled pending watchpoint
   assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (mask_q != '0 && raw_q != '0));
   // Nothing pending in the cycle after reset releases
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (raw_q == '0 && !irq));

endmodule

// File: tb/test_mem_watch_unit.sv
`timescale 1ns/1ps
module test_mem_watch_unit;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_we;
   logic [5:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        txn_valid;
   logic [31:0] txn_addr;
   logic        txn_write;
   logic [3:0]  txn_client;
   logic [3:0]  txn_size;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   mem_watch_unit i_mem_watch_unit (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txn_valid(txn_valid),
      .txn_addr(txn_addr), .txn_write(txn_write), .txn_client(txn_client),
      .txn_size(txn_size), .irq(irq)
   );

   // {addr, write, client, expected raw status}
   localparam logic [40:0] VEC [11] = '{
      {32'h0000_1000, 1'b0, 4'd0,  4'h1},
      {32'h0000_1FFF, 1'b1, 4'd5,  4'h1},
      {32'h0000_0FFF, 1'b0, 4'd0,  4'h0},
      {32'h0000_2000, 1'b0, 4'd0,  4'h4},
      {32'h0000_2000, 1'b1, 4'd0,  4'h0},
      {32'h0000_1800, 1'b1, 4'd2,  4'h3},
      {32'h0000_1800, 1'b0, 4'd2,  4'h1},
      {32'h0000_18FF, 1'b1, 4'd3,  4'h1},
      {32'h0000_2000, 1'b0, 4'd15, 4'h4},
      {32'h0000_1900, 1'b1, 4'd8,  4'h9},
      {32'hFFFF_FFFF, 1'b0, 4'd8,  4'h8}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic txn(input logic [31:0] a, input logic w, input logic [3:0] c,
                      input logic [3:0] s);
      @(negedge clk);
      txn_valid = 1'b1; txn_addr = a; txn_write = w; txn_client = c; txn_size = s;
      @(negedge clk);
      txn_valid = 1'b0;
   endtask

   task automatic clear_all();
      wr(6'd35, 32'hF);
      for (int i = 0; i < 4; i++) wr(6'(8 * i + 7), 32'h0);
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
      txn_valid = 1'b0; txn_addr = '0; txn_write = 1'b0; txn_client = '0; txn_size = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(6'd32, d); check("R1 mask", d, 0);
      rd(6'd33, d); check("R1 raw", d, 0);
      rd(6'd6,  d); check("R1 cap info", d, 0);
      rd(6'd1,  d); check("R1 last addr", d, 0);
      check("R1 irq", 32'(irq), 0);

      // Configure: wp0 wide window any dir all clients; wp1 write only client 2;
      // wp2 one address read only clients 0 and 15; wp3 all memory client 8
      wr(6'd0, 32'h1000); wr(6'd1, 32'h1FFF); wr(6'd2, 3);  wr(6'd3, 32'hFFFF);
      wr(6'd8, 32'h1800); wr(6'd9, 32'h18FF); wr(6'd10, 2); wr(6'd11, 32'h0004);
      wr(6'd16, 32'h2000); wr(6'd17, 32'h2000); wr(6'd18, 1); wr(6'd19, 32'h8001);
      wr(6'd24, 32'h0); wr(6'd25, 32'hFFFF_FFFF); wr(6'd26, 3); wr(6'd27, 32'h0100);

      // R10: configuration read-back
      rd(6'd8,  d); check("R10 first addr", d, 32'h1800);
      rd(6'd10, d); check("R10 dir mask", d, 2);
      rd(6'd11, d); check("R10 client mask", d, 32'h0004);

      // R2 / R9: vector table, raw status after each transaction
      for (int k = 0; k < 11; k++) begin
         txn(VEC[k][40:9], VEC[k][8], VEC[k][7:4], 4'd0);
         rd(6'd33, d);
         check($sformatf("R2/R9 vector %0d", k), d, 32'(VEC[k][3:0]));
         clear_all();
      end

      // R2: matching transaction without valid does not hit
      @(negedge clk);
      txn_addr = 32'h1000; txn_write = 1'b0; txn_client = 4'd0; txn_valid = 1'b0;
      @(negedge clk);
      rd(6'd33, d); check("R2 no valid", d, 0);

      // R3 / R4: unmasked hit pends without irq, mask enables it
      txn(32'h1000, 1'b0, 4'd0, 4'd0);
      rd(6'd33, d); check("R3 raw when masked off", d, 1);
      rd(6'd34, d); check("R4 masked when off", d, 0);
      check("R4 irq off", 32'(irq), 0);
      wr(6'd32, 32'h1);
      rd(6'd34, d); check("R4 masked when on", d, 1);
      check("R4 irq on", 32'(irq), 1);
      wr(6'd32, 32'h2);
      check("R4 irq other bit", 32'(irq), 0);
      wr(6'd32, 32'h0);
      clear_all();

      // R6 / R7: capture freezes, client set accumulates
      txn(32'h2000, 1'b0, 4'd15, 4'd5);
      rd(6'd22, d); check("R6 cap info", d, 32'h851F);
      rd(6'd21, d); check("R6 cap addr", d, 32'h2000);
      rd(6'd20, d); check("R7 cap clients one", d, 32'h8000);
      txn(32'h2000, 1'b0, 4'd0, 4'd3);
      rd(6'd22, d); check("R6 cap info frozen", d, 32'h851F);
      rd(6'd20, d); check("R7 cap clients two", d, 32'h8001);

      // R8: capture ack clears capture, raw status untouched
      wr(6'd23, 32'h0);
      rd(6'd22, d); check("R8 cap info cleared", d, 0);
      rd(6'd20, d); check("R8 cap clients cleared", d, 0);
      rd(6'd21, d); check("R8 cap addr cleared", d, 0);
      rd(6'd33, d); check("R8 raw kept", d, 4);

      // R5: ack clears selected bit only; capture untouched by it
      txn(32'h2000, 1'b1, 4'd0, 4'd0);   // wp0 misses (0x2000), wp2 is read only: no hit
      txn(32'h1000, 1'b1, 4'd1, 4'd0);   // wp0 hit
      rd(6'd33, d); check("R5 before ack", d, 5);
      txn(32'h2000, 1'b0, 4'd0, 4'd2);   // wp2 capture reload
      wr(6'd35, 32'h4);
      rd(6'd33, d); check("R5 selective ack", d, 1);
      rd(6'd22, d); check("R5 capture survives ack", d, 32'h8210);

      // R5: hit in same cycle as ack wins
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 6'd35; reg_wdata = 32'hF;
      txn_valid = 1'b1; txn_addr = 32'h2000; txn_write = 1'b0; txn_client = 4'd0;
      @(negedge clk);
      reg_we = 1'b0; txn_valid = 1'b0;
      rd(6'd33, d); check("R5 hit beats ack", d, 4);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule